// File: doc/BRIEF.md
# Six-Digit Stopwatch Time Counter

This block keeps the running time of a stopwatch as six binary-coded-decimal digits. The digits, from least to most significant, count with moduli ten, ten, ten, six, ten and six. Hundredths and tenths of a second count up into seconds and tens of seconds, and those count up into minutes and tens of minutes. Every digit register sits on one clock. A digit steps only when a counting tick is present and every digit below it sits at its highest value. Carries therefore come from terminal-count detection and never from a digit's zero state.

A surrounding design pulses `tick_en` once per counting period, for example every hundredth of a second. It holds `run` high while the watch is running. Dropping `run` freezes the displayed time without clearing it. A synchronous reset clears the whole chain. Each digit also drives an is-zero flag. A one-cycle pulse marks the moment the full chain wraps from its largest value back to zero.

The moduli are parameters: one modulus for the decade positions and one for the six-step positions. Each digit is as wide as its modulus needs. The active clock edge can also be chosen, with the falling edge as the default.

Top module: `sw_stopwatch_chain`

## Requirements
- R1: While `rst` is high at an active edge, every digit becomes 0 and `wrap_o` becomes 0 on that edge, whatever `run` and `tick_en` are doing.
- R2: On each active edge with `run` and `tick_en` both high and `rst` low, digit 0 steps by one, and wraps from its modulus minus one to 0.
- R3: No digit ever reads a value equal to or above its modulus: 10 at positions 0, 1, 2 and 4, and 6 at positions 3 and 5 by default.
- R4: A digit above position 0 changes only on a counting edge where every lower digit is at its terminal value (modulus minus one). Intermediate steps of a lower digit, such as 3 to 4, leave it unchanged.
- R5: When a digit steps from its terminal value it becomes 0, and the next digit up steps on that same edge.
- R6: The first counting edge after reset makes digit 0 read 1 and leaves every other digit at 0.
- R7: `zero_o[i]` is high exactly when digit i reads 0.
- R8: `wrap_o` is high for exactly the one cycle after the edge on which all six digits stood at their terminal values and a count was taken. On that edge every digit returns to 0. `wrap_o` is low at all other times.
- R9: An edge with `run` low or `tick_en` low leaves every digit unchanged.
- R10: The digits change only at the selected active clock edge, which is the falling edge by default. They hold across the other edge.
- R11: `digits_o` packs the digits least significant first, starting at bit 0. Digit i takes ceil(log2(modulus)) bits, with a minimum of 1. The default layout is 4,4,4,3,4,3 bits, 22 bits in all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; digits update on the selected edge |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count gate; low freezes the time |
| tick_en | input | 1 | One-cycle counting tick |
| digits_o | output | BUS_W (22) | Packed digit values, digit 0 in the low bits |
| zero_o | output | 6 | Per-digit is-zero flags |
| wrap_o | output | 1 | One-cycle pulse after the full chain wraps to zero |

## Verification
Every digit register drives `digits_o` directly. A wrong count, a missed or spurious carry, or an out-of-range value therefore appears at the ports right after the active edge that caused it, and stays visible until a later edge overwrites it. A wrong carry term is exposed on the first lower-digit rollover, or on a 3-to-4 step that should not propagate. A zero-detect wrongly used as a carry shows up on the first counting edge after reset. A small-modulus configuration walks the complete wrap several times, so a wrap fault appears within a few hundred ticks.

// File: rtl/sw_pkg.sv
package sw_pkg;

   localparam int unsigned NUM_DIG = 6;

   // Positions 3 and 5 use the six-step modulus; the rest are decades.
   function automatic int unsigned dig_mod(input int unsigned idx,
                                           input int unsigned dm,
                                           input int unsigned sm);
      return (idx == 3 || idx == 5) ? sm : dm;
   endfunction

   function automatic int unsigned dig_w(input int unsigned m);
      return (m <= 2) ? 1 : $clog2(m);
   endfunction

   function automatic int unsigned dig_off(input int unsigned idx,
                                           input int unsigned dm,
                                           input int unsigned sm);
      int unsigned s;
      s = 0;
      for (int unsigned k = 0; k < idx; k++)
         s += dig_w(dig_mod(k, dm, sm));
      return s;
   endfunction

   function automatic int unsigned bus_w(input int unsigned dm,
                                         input int unsigned sm);
      return dig_off(NUM_DIG, dm, sm);
   endfunction

endpackage

// File: rtl/sw_digit.sv
module sw_digit #(
   parameter int unsigned MOD       = 10,
   parameter int unsigned W         = 4,
   parameter bit          FALL_EDGE = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] q,
   output logic         term,
   output logic         zero
);

   localparam logic [W-1:0] TERM_V = W'(MOD - 1);

   logic [W-1:0] q_r;
   logic [W-1:0] q_nx;

   always_comb begin
      if (rst)
         q_nx = '0;
      else if (inc)
         q_nx = (q_r == TERM_V) ? '0 : q_r + W'(1);
      else
         q_nx = q_r;
   end

   generate
      if (FALL_EDGE) begin : g_fall
         always_ff @(negedge clk) q_r <= q_nx;
      end else begin : g_rise
         always_ff @(posedge clk) q_r <= q_nx;
      end
   endgenerate

   assign q    = q_r;
   assign term = (q_r == TERM_V);
   assign zero = (q_r == '0);

endmodule

// File: rtl/sw_carry_chain.sv
module sw_carry_chain #(
   parameter int unsigned N = 6
) (
   input  logic         adv,
   input  logic [N-1:0] term,
   output logic [N-1:0] inc,
   output logic         wrap_set
);

   assign inc[0] = adv;

   generate
      for (genvar g = 1; g < N; g++) begin : g_link
         assign inc[g] = inc[g-1] & term[g-1];
      end
   endgenerate

   assign wrap_set = inc[N-1] & term[N-1];

endmodule

// File: rtl/sw_wrap_reg.sv
module sw_wrap_reg #(
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic set,
   output logic q
);

   logic q_r;
   logic q_nx;

   assign q_nx = set & ~rst;

   generate
      if (FALL_EDGE) begin : g_fall
         always_ff @(negedge clk) q_r <= q_nx;
      end else begin : g_rise
         always_ff @(posedge clk) q_r <= q_nx;
      end
   endgenerate

   assign q = q_r;

endmodule

// File: rtl/sw_stopwatch_chain.sv
module sw_stopwatch_chain #(
   parameter  int unsigned DEC_MOD   = 10,
   parameter  int unsigned SIX_MOD   = 6,
   parameter  bit          FALL_EDGE = 1'b1,
   localparam int unsigned NDIG      = sw_pkg::NUM_DIG,
   localparam int unsigned BUS_W     = sw_pkg::bus_w(DEC_MOD, SIX_MOD)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic             tick_en,
   output logic [BUS_W-1:0] digits_o,
   output logic [NDIG-1:0]  zero_o,
   output logic             wrap_o
);

   generate
      if (DEC_MOD < 2) begin : g_bad_dec
         $error("DEC_MOD must be at least 2");
      end
      if (SIX_MOD < 2) begin : g_bad_six
         $error("SIX_MOD must be at least 2");
      end
   endgenerate

   logic            adv;
   logic [NDIG-1:0] term;
   logic [NDIG-1:0] inc;
   logic            wrap_set;

   assign adv = run & tick_en;

   generate
      for (genvar g = 0; g < NDIG; g++) begin : g_dig
         localparam int unsigned M   = sw_pkg::dig_mod(g, DEC_MOD, SIX_MOD);
         localparam int unsigned W   = sw_pkg::dig_w(M);
         localparam int unsigned OFF = sw_pkg::dig_off(g, DEC_MOD, SIX_MOD);

         sw_digit #(.MOD(M), .W(W), .FALL_EDGE(FALL_EDGE)) u_dig (
            .clk  (clk),
            .rst  (rst),
            .inc  (inc[g]),
            .q    (digits_o[OFF +: W]),
            .term (term[g]),
            .zero (zero_o[g])
         );
      end
   endgenerate

   sw_carry_chain #(.N(NDIG)) u_chain (
      .adv      (adv),
      .term     (term),
      .inc      (inc),
      .wrap_set (wrap_set)
   );

   sw_wrap_reg #(.FALL_EDGE(FALL_EDGE)) u_wrap (
      .clk (clk),
      .rst (rst),
      .set (wrap_set),
      .q   (wrap_o)
   );

endmodule

// File: rtl/sw_stopwatch_chain_chk.sv
module sw_stopwatch_chain_chk #(
   parameter  int unsigned DEC_MOD   = 10,
   parameter  int unsigned SIX_MOD   = 6,
   parameter  bit          FALL_EDGE = 1'b1,
   localparam int unsigned NDIG      = sw_pkg::NUM_DIG,
   localparam int unsigned BUS_W     = sw_pkg::bus_w(DEC_MOD, SIX_MOD)
) (
   input logic             clk,
   input logic             rst,
   input logic             run,
   input logic             tick_en,
   input logic [BUS_W-1:0] digits_o,
   input logic [NDIG-1:0]  zero_o,
   input logic             wrap_o
);

   logic            aclk;
   logic            adv;
   logic [7:0]      dv [NDIG];
   logic [NDIG-1:0] tv;

   assign aclk = FALL_EDGE ? ~clk : clk;
   assign adv  = run & tick_en;

   generate
      for (genvar g = 0; g < NDIG; g++) begin : g_f
         localparam int unsigned M   = sw_pkg::dig_mod(g, DEC_MOD, SIX_MOD);
         localparam int unsigned W   = sw_pkg::dig_w(M);
         localparam int unsigned OFF = sw_pkg::dig_off(g, DEC_MOD, SIX_MOD);

         assign dv[g] = 8'(digits_o[OFF +: W]);
         assign tv[g] = (dv[g] == 8'(M - 1));

         p_no_overflow_r3: assert property (@(posedge aclk) disable iff (rst)
            dv[g] < 8'(M));

         if (g > 0) begin : g_up
            p_carry_only_r4: assert property (@(posedge aclk) disable iff (rst)
               !(adv && (&tv[g-1:0])) |=> $stable(dv[g]));
         end
      end
   endgenerate

   p_clear_r1: assert property (@(posedge aclk)
      rst |=> (digits_o == '0 && !wrap_o));

   p_step_r2: assert property (@(posedge aclk) disable iff (rst)
      adv |=> (32'(dv[0]) == (32'($past(dv[0])) + 1) % DEC_MOD));

   p_first_r6: assert property (@(posedge aclk) disable iff (rst)
      (digits_o == '0 && adv) |=> (digits_o == BUS_W'(1)));

   p_zero_fall_r7: assert property (@(posedge aclk) disable iff (rst)
      $fell(zero_o[0]) |-> $past(adv));

   p_wrap_cause_r8: assert property (@(posedge aclk) disable iff (rst)
      wrap_o |-> $past(adv && (&tv)));

   p_wrap_zero_r8: assert property (@(posedge aclk) disable iff (rst)
      wrap_o |-> (digits_o == '0));

   p_hold_r9: assert property (@(posedge aclk) disable iff (rst)
      !adv |=> $stable(digits_o));

endmodule

bind sw_stopwatch_chain sw_stopwatch_chain_chk #(
   .DEC_MOD   (DEC_MOD),
   .SIX_MOD   (SIX_MOD),
   .FALL_EDGE (FALL_EDGE)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .run      (run),
   .tick_en  (tick_en),
   .digits_o (digits_o),
   .zero_o   (zero_o),
   .wrap_o   (wrap_o)
);

// File: tb/sim_sw_stopwatch_chain.sv
`timescale 1ns/1ps
module sim_sw_stopwatch_chain;

   localparam int DM0 = 10, SM0 = 6;
   localparam int DM1 = 3,  SM1 = 2;
   localparam int P1  = DM1 * DM1 * DM1 * SM1 * DM1 * SM1;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        run = 1'b1;
   logic        tick_en = 1'b1;
   logic [21:0] dig0;
   logic [5:0]  zf0;
   logic        wr0;
   logic [9:0]  dig1;
   logic [5:0]  zf1;
   logic        wr1;

   int n_chk = 0;
   int n_bad = 0;
   int ref0 = 0;
   int ref1 = 0;
   bit expw1 = 1'b0;
   int wraps_seen = 0;
   logic [21:0] snap0;
   logic [9:0]  snap1;

   always #5 clk = ~clk;

   sw_stopwatch_chain #(.DEC_MOD(DM0), .SIX_MOD(SM0)) u0 (
      .clk(clk), .rst(rst), .run(run), .tick_en(tick_en),
      .digits_o(dig0), .zero_o(zf0), .wrap_o(wr0));

   sw_stopwatch_chain #(.DEC_MOD(DM1), .SIX_MOD(SM1)) u1 (
      .clk(clk), .rst(rst), .run(run), .tick_en(tick_en),
      .digits_o(dig1), .zero_o(zf1), .wrap_o(wr1));

   function automatic int mod_of(int i, int dm, int sm);
      return (i == 3 || i == 5) ? sm : dm;
   endfunction

   function automatic int w_of(int m);
      return (m <= 2) ? 1 : $clog2(m);
   endfunction

   function automatic int ref_dig(int n, int i, int dm, int sm);
      int v = n;
      for (int k = 0; k < i; k++) v = v / mod_of(k, dm, sm);
      return v % mod_of(i, dm, sm);
   endfunction

   // R11: field i sits above the widths of all lower digits.
   function automatic int field(logic [31:0] bus, int i, int dm, int sm);
      int off = 0;
      int w = w_of(mod_of(i, dm, sm));
      for (int k = 0; k < i; k++) off += w_of(mod_of(k, dm, sm));
      return int'((bus >> off) & ((32'd1 << w) - 1));
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_inst(logic [31:0] bus, logic [5:0] zf, logic wr,
                             int n, int dm, int sm, bit ew);
      for (int i = 0; i < 6; i++) begin
         int a = field(bus, i, dm, sm);
         int e = ref_dig(n, i, dm, sm);
         // R2 for digit 0; R4/R5 carry behaviour for the upper digits.
         chk(a == e, (i == 0) ? "R2 digit0" : "R4 R5 upper digit", a, e);
         chk(a < mod_of(i, dm, sm), "R3 range", a, mod_of(i, dm, sm) - 1);
         chk(zf[i] == (e == 0), "R7 zero flag", int'(zf[i]), int'(e == 0));
      end
      chk(wr == ew, "R8 wrap pulse", int'(wr), int'(ew));
   endtask

   task automatic step(bit r, bit ru, bit te);
      @(posedge clk);
      #1;
      // R10: nothing moves at the rising edge.
      chk(dig0 == snap0, "R10 hold at rising edge", int'(dig0), int'(snap0));
      chk(dig1 == snap1, "R10 hold at rising edge", int'(dig1), int'(snap1));
      rst = r; run = ru; tick_en = te;
      @(negedge clk);
      #2;
      if (r) begin
         ref0 = 0; ref1 = 0; expw1 = 1'b0;
      end else if (ru && te) begin
         ref0++;
         expw1 = (ref1 == P1 - 1);
         ref1 = (ref1 + 1) % P1;
      end else begin
         expw1 = 1'b0;   // R9: no count, no change
      end
      if (wr1) wraps_seen++;
      check_inst(32'(dig0), zf0, wr0, ref0, DM0, SM0, 1'b0);
      check_inst(32'(dig1), zf1, wr1, ref1, DM1, SM1, expw1);
      snap0 = dig0; snap1 = dig1;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 act=1 exp=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: reset overrides an active tick.
      for (int c = 0; c < 3; c++) step(1'b1, 1'b1, 1'b1);
      chk(dig0 == '0, "R1 reset digits", int'(dig0), 0);
      chk(zf0 == 6'h3f, "R1 reset zero flags", int'(zf0), 63);
      // R6: first count moves only digit 0.
      step(1'b0, 1'b1, 1'b1);
      chk(dig0 == 22'd1, "R6 first count", int'(dig0), 1);
      chk(dig1 == 10'd1, "R6 first count", int'(dig1), 1);
      for (int i = 0; i < 2400; i++) begin
         bit ru = !((i % 37) >= 34);
         bit te = ((i % 11) != 5);
         bit r  = (i == 1700);
         step(r, ru, te);
      end
      // R8: the small configuration must have wrapped several times.
      chk(wraps_seen >= 3, "R8 wraps observed", wraps_seen, 3);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule